// File: doc/BRIEF.md
# Serial Register Access Slave (24-bit Command/Data Frames)

This block lets an external host read and write a small bank of 16-bit control registers over a four-wire serial link (clock, active-low select, data in, data out). Every access is one 24-bit frame. An 8-bit command byte comes first and picks the register and the direction. Sixteen data bits follow. In a write they arrive on the data input. In a read they leave on the data output.

The serial clock, select and data-in pins are brought into the on-chip clock domain through synchronizer stages. The serial clock is then edge-detected, so the logic needs no clock of its own. Incoming bits are taken on rising serial-clock edges. Outgoing bits change on falling edges. The host may idle the serial clock low (polarity 0, phase 0) or high (polarity 1, phase 1).

One slot of the bank is a read-only temperature word. It is fed from a chip input and returned unchanged, as two's-complement data. All register contents are also presented in parallel to the surrounding logic.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset every writable register holds 0, `dout` is 0 and `doutOe` is 0.
- R2: A falling edge on `csN` opens a frame. The first 8 rising `sclk` edges shift in a command byte, MSB first. Command bit 7 is the direction (1 = read, 0 = write) and bits 6..0 are the register address.
- R3: In a write frame, the next 16 rising edges shift in data, MSB first. The word is stored into the addressed register on the 24th rising edge and then appears on `regBus` at bits [addr*16 +: 16].
- R4: In a read frame, the addressed word is captured once the 8th command bit is in. It appears on `dout` MSB first, one bit per falling `sclk` edge, so each bit is valid before the rising edge that follows. `doutOe` is 1 during the read data phase.
- R5: The same frames work with `sclk` idling low and with `sclk` idling high.
- R6: If `csN` rises before the 24th rising edge, the frame is dropped: no register changes, and the next frame starts from bit 0.
- R7: Addresses that are 8 or greater read as 0, and writes to them change nothing.
- R8: Address 7 returns the `tempValue` input bit for bit (a signed two's-complement word). Writes to address 7 are ignored.
- R9: `dout` is 0 while `csN` is high, during the command byte, and for the whole of a write frame.
- R10: The value on `din` during the data phase of a read frame has no effect on any register.
- R11: Rising edges after the 24th in the same frame are ignored, and a write is stored exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | On-chip clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low frame select |
| din | input | 1 | Serial data from the host |
| tempValue | input | DATA_W | Two's-complement temperature word served at address 7 |
| dout | output | 1 | Serial data to the host |
| doutOe | output | 1 | High while read data is being driven |
| regBus | output | NUM_REGS*DATA_W | Parallel view of all register slots |

## Verification
The bench runs complete frames in both clock modes and samples `dout` just before each rising `sclk` edge.

- A design that is off by one when it captures read data would present the second bit where the MSB belongs.
- A design that shifts on the first falling edge in idle-high mode would lose the MSB.
- A frame cut short at 20 bits must leave its target untouched. A commit on the wrong count, or a counter that does not clear on select release, would corrupt the register or the frame after it.
- Writes to an unmapped address, to the temperature slot, and extra clocks past bit 24 all target decode and double-commit faults; each would show up as an unexpected change on `regBus`.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  // Strobes from the frame control to the datapath, one cycle wide each.
  typedef struct packed {
    logic idle;      // select inactive: clear frame state
    logic sampleBit; // take dinBit into the input shifter
    logic dinBit;    // synchronized serial input bit
    logic cmdDone;   // this sample completes the command byte
    logic commit;    // this sample completes the data word
    logic driveBit;  // advance the output shifter onto dout
  } ctrlStrobe_t;

endpackage

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CMD_W       = 8,
  parameter int DATA_W      = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkIn,
  input  logic        csNIn,
  input  logic        dinIn,
  output ctrlStrobe_t strobe
);

  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CMD_CNT    = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] FRAME_CNT  = CNT_W'(FRAME_W);

  logic [SYNC_STAGES-1:0] sclkSync, csSync, dinSync;
  logic                   sclkS, csS, dinS, sclkPrev;
  logic [CNT_W-1:0]       bitCnt;
  logic                   riseEvt, fallEvt, frameOpen, dataPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      dinSync  <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclkIn};
      csSync   <= {csSync[SYNC_STAGES-2:0], csNIn};
      dinSync  <= {dinSync[SYNC_STAGES-2:0], dinIn};
      sclkPrev <= sclkS;
    end
  end

  assign sclkS = sclkSync[SYNC_STAGES-1];
  assign csS   = csSync[SYNC_STAGES-1];
  assign dinS  = dinSync[SYNC_STAGES-1];

  assign riseEvt   = !csS &&  sclkS && !sclkPrev;
  assign fallEvt   = !csS && !sclkS &&  sclkPrev;
  assign frameOpen = (bitCnt < FRAME_CNT);
  assign dataPhase = (bitCnt >= CMD_CNT) && frameOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (csS) begin
      bitCnt <= '0;
    end else if (riseEvt && frameOpen) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.idle      = csS;
    strobe.sampleBit = riseEvt && frameOpen;
    strobe.dinBit    = dinS;
    strobe.cmdDone   = riseEvt && (bitCnt == CMD_LAST);
    strobe.commit    = riseEvt && (bitCnt == FRAME_LAST);
    strobe.driveBit  = fallEvt && dataPhase;
  end

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FRAME_CNT); // R11

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(csS) && (bitCnt != $past(bitCnt))) |-> (bitCnt == $past(bitCnt) + 1'b1)); // R2

endmodule

// File: rtl/spi_reg_dp.sv
module spi_reg_dp
  import spi_reg_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int DATA_W    = 16,
  parameter int CMD_W     = 8,
  parameter int TEMP_ADDR = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strobe,
  input  logic [DATA_W-1:0]          tempValue,
  output logic                       dout,
  output logic                       doutOe,
  output logic [NUM_REGS*DATA_W-1:0] regBus
);

  localparam int ADDR_W = CMD_W - 1;
  localparam int SHIFT_W = DATA_W - 1;

  logic [SHIFT_W-1:0] shiftIn;
  logic [CMD_W-1:0]   cmdReg;
  logic [CMD_W-1:0]   cmdNext;
  logic               cmdValid;
  logic               rdMode;
  logic [DATA_W-1:0]  outShift;
  logic [DATA_W-1:0]  rdWord;
  logic [DATA_W-1:0]  wrWord;
  logic [DATA_W-1:0]  regQ [NUM_REGS];

  assign cmdNext = {shiftIn[CMD_W-2:0], strobe.dinBit};
  assign wrWord  = {shiftIn, strobe.dinBit};

  // Input shifter: holds the bits seen so far in the frame.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftIn <= '0;
    end else if (strobe.sampleBit) begin
      shiftIn <= {shiftIn[SHIFT_W-2:0], strobe.dinBit};
    end
  end

  // Command latch and read-mode flag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg   <= '0;
      cmdValid <= 1'b0;
      rdMode   <= 1'b0;
    end else if (strobe.idle) begin
      cmdValid <= 1'b0;
      rdMode   <= 1'b0;
    end else if (strobe.cmdDone) begin
      cmdReg   <= cmdNext;
      cmdValid <= 1'b1;
      rdMode   <= cmdNext[CMD_W-1];
    end
  end

  // Read mux: unmapped addresses return zero.
  always_comb begin
    rdWord = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (cmdNext[ADDR_W-1:0] == ADDR_W'(i)) rdWord = regQ[i];
    end
  end

  // Output shifter: loaded at end of command, one bit per falling edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      dout     <= 1'b0;
    end else if (strobe.idle) begin
      outShift <= '0;
      dout     <= 1'b0;
    end else if (strobe.cmdDone) begin
      outShift <= cmdNext[CMD_W-1] ? rdWord : '0;
      dout     <= 1'b0;
    end else if (strobe.driveBit && rdMode) begin
      dout     <= outShift[DATA_W-1];
      outShift <= {outShift[DATA_W-2:0], 1'b0};
    end
  end

  assign doutOe = rdMode;

  // Register bank: one generate slot per address.
  for (genvar g = 0; g < NUM_REGS; g++) begin : gSlot
    if (g == TEMP_ADDR) begin : gTemp
      assign regQ[g] = tempValue;
    end else begin : gRw
      logic wrHit;
      assign wrHit = strobe.commit && cmdValid && !cmdReg[CMD_W-1] &&
                     (cmdReg[ADDR_W-1:0] == ADDR_W'(g));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)      regQ[g] <= '0;
        else if (wrHit) regQ[g] <= wrWord;
      end

      AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rstN)
        (regQ[g] != $past(regQ[g])) |-> $past(strobe.commit)); // R6
    end
    assign regBus[g*DATA_W +: DATA_W] = regQ[g];
  end

  AST_COMMIT_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> cmdValid); // R3

  AST_DOUT_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.idle |=> (dout == 1'b0)); // R9

  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    doutOe |-> cmdReg[CMD_W-1]); // R4

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int DATA_W      = 16,
  parameter int CMD_W       = 8,
  parameter int TEMP_ADDR   = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclk,
  input  logic                       csN,
  input  logic                       din,
  input  logic [DATA_W-1:0]          tempValue,
  output logic                       dout,
  output logic                       doutOe,
  output logic [NUM_REGS*DATA_W-1:0] regBus
);

  ctrlStrobe_t strobe;

  spi_reg_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .CMD_W      (CMD_W),
    .DATA_W     (DATA_W)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .sclkIn(sclk),
    .csNIn (csN),
    .dinIn (din),
    .strobe(strobe)
  );

  spi_reg_dp #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .CMD_W    (CMD_W),
    .TEMP_ADDR(TEMP_ADDR)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .tempValue(tempValue),
    .dout     (dout),
    .doutOe   (doutOe),
    .regBus   (regBus)
  );

endmodule

// File: tb/spi_reg_slave_tb.sv
`timescale 1ns/1ps
module spi_reg_slave_tb_top;

  localparam int HP = 6;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         sclk = 1'b0;
  logic         csN = 1'b1;
  logic         din = 1'b0;
  logic [15:0]  tempValue = 16'hFF38;
  logic         dout, doutOe;
  logic [127:0] regBus;

  int checks = 0;
  int fails  = 0;
  logic [15:0] expReg [8];

  always #4 clk = ~clk;

  spi_reg_slave dut_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .din(din),
    .tempValue(tempValue), .dout(dout), .doutOe(doutOe), .regBus(regBus)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One frame. quietErr counts dout/doutOe faults where R9 wants them low.
  task automatic xfer(input bit mode3, input logic [7:0] cmd, input logic [15:0] wd,
                      input int nbits, output logic [15:0] rd, output int quietErr);
    logic [23:0] fr;
    fr = {cmd, wd};
    rd = '0;
    quietErr = 0;
    sclk = mode3;
    waitCyc(HP);
    csN = 1'b0;
    waitCyc(HP);
    for (int i = 0; i < nbits; i++) begin
      if (mode3) sclk = 1'b0;
      din = (i < 24) ? fr[23-i] : 1'b1;
      waitCyc(HP);
      if (i < 8 || !cmd[7]) begin
        if (dout !== 1'b0) quietErr++;
      end
      if (i < 8 && doutOe !== 1'b0) quietErr++;
      if (i >= 8 && i < 24 && cmd[7]) rd[23-i] = dout;
      sclk = 1'b1;
      waitCyc(HP);
      if (!mode3) sclk = 1'b0;
    end
    waitCyc(HP);
    csN = 1'b1;
    waitCyc(4*HP);
  endtask

  task automatic checkBus(input string tag);
    for (int a = 0; a < 8; a++)
      chk(regBus[a*16 +: 16] === expReg[a], tag, {16'h0, regBus[a*16 +: 16]}, {16'h0, expReg[a]});
  endtask

  task automatic t_reset();
    chk(regBus[111:0] === '0, "R1 regs zero", regBus[31:0], 32'h0);
    chk(dout === 1'b0, "R1 dout low", {31'h0, dout}, 32'h0);
    chk(doutOe === 1'b0, "R1 doutOe low", {31'h0, doutOe}, 32'h0);
  endtask

  task automatic t_mode0_rw();
    logic [15:0] rd; int q;
    xfer(1'b0, 8'h02, 16'hA5C3, 24, rd, q);
    expReg[2] = 16'hA5C3;
    chk(q == 0, "R9 write frame dout low", q, 0);
    chk(regBus[2*16 +: 16] === 16'hA5C3, "R3 write reg2", {16'h0, regBus[2*16 +: 16]}, 32'hA5C3);
    xfer(1'b0, 8'h82, 16'h0000, 24, rd, q);
    chk(rd === 16'hA5C3, "R4 R2 read reg2 mode0", {16'h0, rd}, 32'hA5C3);
    chk(q == 0, "R9 command phase quiet", q, 0);
    chk(dout === 1'b0 && doutOe === 1'b0, "R9 idle after read", {30'h0, doutOe, dout}, 32'h0);
  endtask

  task automatic t_mode3();
    logic [15:0] rd; int q;
    xfer(1'b1, 8'h05, 16'h8001, 24, rd, q);
    expReg[5] = 16'h8001;
    chk(regBus[5*16 +: 16] === 16'h8001, "R5 mode3 write reg5", {16'h0, regBus[5*16 +: 16]}, 32'h8001);
    xfer(1'b1, 8'h85, 16'h0000, 24, rd, q);
    chk(rd === 16'h8001, "R5 mode3 read reg5", {16'h0, rd}, 32'h8001);
    xfer(1'b1, 8'h82, 16'h0000, 24, rd, q);
    chk(rd === 16'hA5C3, "R5 mode3 read reg2", {16'h0, rd}, 32'hA5C3);
  endtask

  task automatic t_abort();
    logic [15:0] rd; int q;
    xfer(1'b0, 8'h02, 16'h1234, 20, rd, q);
    checkBus("R6 aborted write");
    xfer(1'b0, 8'h03, 16'h0F0F, 24, rd, q);
    expReg[3] = 16'h0F0F;
    chk(regBus[3*16 +: 16] === 16'h0F0F, "R6 frame after abort", {16'h0, regBus[3*16 +: 16]}, 32'h0F0F);
  endtask

  task automatic t_unmapped();
    logic [15:0] rd; int q;
    xfer(1'b0, 8'h40, 16'hDEAD, 24, rd, q);
    xfer(1'b0, 8'h0A, 16'hBEEF, 24, rd, q);
    checkBus("R7 unmapped write");
    xfer(1'b0, 8'hC0, 16'h0000, 24, rd, q);
    chk(rd === 16'h0000, "R7 unmapped read", {16'h0, rd}, 32'h0);
  endtask

  task automatic t_temp();
    logic [15:0] rd; int q;
    xfer(1'b0, 8'h87, 16'h0000, 24, rd, q);
    chk(rd === 16'hFF38, "R8 temp read", {16'h0, rd}, 32'hFF38);
    xfer(1'b0, 8'h07, 16'h0001, 24, rd, q);
    xfer(1'b1, 8'h87, 16'h0000, 24, rd, q);
    chk(rd === 16'hFF38, "R8 temp write ignored", {16'h0, rd}, 32'hFF38);
    tempValue = 16'h0064;
    xfer(1'b0, 8'h87, 16'h0000, 24, rd, q);
    chk(rd === 16'h0064, "R8 temp positive", {16'h0, rd}, 32'h0064);
  endtask

  task automatic t_din_dontcare();
    logic [15:0] rd; int q;
    xfer(1'b0, 8'h85, 16'hFFFF, 24, rd, q);
    chk(rd === 16'h8001, "R10 read with din high", {16'h0, rd}, 32'h8001);
    checkBus("R10 registers untouched");
  endtask

  task automatic t_extra_clocks();
    logic [15:0] rd; int q;
    xfer(1'b0, 8'h01, 16'h00F0, 30, rd, q);
    expReg[1] = 16'h00F0;
    chk(regBus[1*16 +: 16] === 16'h00F0, "R11 extra clocks ignored", {16'h0, regBus[1*16 +: 16]}, 32'h00F0);
    checkBus("R11 bank after extra clocks");
  endtask

  initial begin
    for (int a = 0; a < 8; a++) expReg[a] = 16'h0;
    expReg[7] = 16'hFF38;
    waitCyc(5);
    t_reset();
    rstN = 1'b1;
    waitCyc(5);
    t_reset();
    t_mode0_rw();
    t_mode3();
    t_abort();
    t_unmapped();
    t_temp();
    expReg[7] = 16'h0064;
    t_din_dontcare();
    t_extra_clocks();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule